// File: doc/BRIEF.md
# Native Request to AXI Burst Bridge

This block takes one granted request from an arbiter and carries it out as a single burst on an AXI-style master interface with a 256-bit data path. A request names the requesting port, a start address, a direction flag and a beat count. A read request drives the read address channel, then passes each returned data beat straight to the requestors' shared read data bus. A one-hot select strobe marks the port that owns the beat. A write request drives the write address channel, then presents the owning requestor's data on the write channel. A one-hot ack strobe tells that requestor each time the slave takes a beat, so that it moves on to its next word.

Only one transfer is in flight at a time. The bridge accepts a new request only while idle and reports the end of each burst with a one-cycle done pulse, so that the arbiter can grant again. Address-channel bursts are always incrementing, 32 bytes per beat, with the length field set to the beat count minus one. The beat count must be between 1 and 255.

Top module: `axi_req_bridge`

## Requirements
- R1: After a synchronous active-high reset, req_ready is 1, done is 0, and arvalid, awvalid, wvalid, rready, bready, every bit of rd_sel and every bit of wr_ack are 0.
- R2: A request is taken only while req_ready is 1. A req_valid seen while busy is ignored: after the current burst ends, no new address phase starts unless a request is presented again.
- R3: For a read, arvalid rises the cycle after acceptance with araddr equal to the request address, arlen equal to the beat count minus 1, arsize equal to 3'b101 (32 bytes) and arburst equal to 2'b01 (INCR). arvalid and araddr are held until arready is seen.
- R4: For a write, awvalid, awaddr, awlen, awsize and awburst follow the same rules on the write address channel. They are held until awready is seen.
- R5: During read data, rready is 1. In any cycle with rvalid high, rd_sel has exactly bit <port> set and rd_data equals rdata in that same cycle. In any cycle with rvalid low, rd_sel is all zero.
- R6: During write data, wvalid is 1 and wdata equals wr_data. wr_ack has exactly bit <port> set in cycles where wready is high, and is zero in cycles where wready is low.
- R7: wlast is 1 only while the final beat is offered, that is after (beat count minus 1) beats have been accepted.
- R8: After the final write beat is accepted, wvalid drops and bready stays 1 until bvalid is seen. done is 1 in the cycle after that handshake.
- R9: For a read, done is 1 in the cycle after the beat with rlast high is accepted, and done lasts a single cycle.
- R10: rd_sel and wr_ack are each at most one-hot and are never nonzero at the same time. Both are zero whenever the bridge is idle.
- R11: In the cycle where done is 1, req_ready is also 1. A request presented in that cycle is taken at once, and its address phase starts in the next cycle.
- R12: A one-beat burst (beat count 1) drives arlen or awlen to 0, and it drives wlast on the first and only write beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Granted request present |
| req_ready | output | 1 | Bridge idle, request accepted this cycle if valid |
| req_port | input | 2 | Requesting port number |
| req_addr | input | 32 | Burst start address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 8 | Beat count, 1 to 255 |
| done | output | 1 | One-cycle burst completion pulse |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | 32 | Read address |
| arlen | output | 8 | Read beats minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | 256 | Read data beat |
| rlast | input | 1 | Final read beat |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | 32 | Write address |
| awlen | output | 8 | Write beats minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 256 | Write data beat |
| wlast | output | 1 | Final write beat |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| rd_sel | output | 4 | One-hot read beat strobe per port |
| rd_data | output | 256 | Read data toward requestors |
| wr_ack | output | 4 | One-hot write beat accept strobe per port |
| wr_data | input | 256 | Write data from owning requestor |

## Verification
The completion pulse of one burst and the acceptance of the next request can land in the same cycle. To provoke this, the bench raises a new write request together with the final read beat and holds it across the done cycle. It then expects done and req_ready high together, followed by the write address phase for the new port one cycle later. A second overlap is the acceptance of a write beat together with the move into the response phase. The one-beat write stresses this by putting wlast, the ack strobe and that transition all on the first beat.

// File: rtl/axib_pkg.sv
package axib_pkg;

    parameter int PORT_N = 4;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 256;
    parameter int LEN_W  = 8;

    localparam int PID_W = (PORT_N > 1) ? $clog2(PORT_N) : 1;

    localparam logic [2:0] BEAT_SIZE  = 3'($clog2(DATA_W / 8));
    localparam logic [1:0] BURST_INCR = 2'b01;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_DATA,
        PH_RESP
    } phase_e;

    typedef struct packed {
        logic [PID_W-1:0]  port;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [LEN_W-1:0]  len;
    } job_t;

    // Index of the final beat of a burst of len beats.
    function automatic logic [LEN_W-1:0] final_beat(input logic [LEN_W-1:0] len);
        return LEN_W'(len - 1'b1);
    endfunction

endpackage

// File: rtl/axib_seq.sv
module axib_seq
    import axib_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  job_t   job_in,
    output logic   req_ready,
    output job_t   job,
    output logic   done,
    output logic   arvalid,
    input  logic   arready,
    output logic   awvalid,
    input  logic   awready,
    input  logic   rvalid,
    input  logic   rlast,
    output logic   rready,
    output logic   wvalid,
    input  logic   wready,
    output logic   wlast,
    input  logic   bvalid,
    output logic   bready
);

    phase_e           phase;
    logic [LEN_W-1:0] beats;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            job   <= '0;
            beats <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        job   <= job_in;
                        beats <= '0;
                        phase <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    if (job.wr ? awready : arready) begin
                        phase <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (!job.wr) begin
                        if (rvalid && rlast) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end
                    end else if (wready) begin
                        beats <= beats + 1'b1;
                        if (wlast) begin
                            phase <= PH_RESP;
                        end
                    end
                end
                PH_RESP: begin
                    if (bvalid) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (phase == PH_IDLE);
        arvalid   = (phase == PH_ADDR) && !job.wr;
        awvalid   = (phase == PH_ADDR) &&  job.wr;
        rready    = (phase == PH_DATA) && !job.wr;
        wvalid    = (phase == PH_DATA) &&  job.wr;
        wlast     = wvalid && (beats == final_beat(job.len));
        bready    = (phase == PH_RESP);
    end

    AST_BUSY_KEEPS_JOB: assert property (@(posedge clk) disable iff (rst)
        !req_ready && req_valid |=> $stable(job)) else $error("busy request altered job"); // R2
    AST_AR_HELD: assert property (@(posedge clk) disable iff (rst)
        arvalid && !arready |=> arvalid && $stable(job)) else $error("arvalid dropped early"); // R3
    AST_AW_HELD: assert property (@(posedge clk) disable iff (rst)
        awvalid && !awready |=> awvalid && $stable(job)) else $error("awvalid dropped early"); // R4
    AST_LAST_W_TO_RESP: assert property (@(posedge clk) disable iff (rst)
        wvalid && wready && wlast |=> bready && !wvalid) else $error("no response wait"); // R7
    AST_B_DONE: assert property (@(posedge clk) disable iff (rst)
        bvalid && bready |=> done && req_ready) else $error("missing write done"); // R8
    AST_R_DONE: assert property (@(posedge clk) disable iff (rst)
        rvalid && rready && rlast |=> done && req_ready) else $error("missing read done"); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than a cycle"); // R9

endmodule

// File: rtl/axib_route.sv
module axib_route
    import axib_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic [PID_W-1:0] owner,
    input  logic             rd_beat,
    input  logic             wr_beat,
    output logic [PORT_N-1:0] rd_sel,
    output logic [PORT_N-1:0] wr_ack
);

    for (genvar g = 0; g < PORT_N; g++) begin : g_port
        assign rd_sel[g] = rd_beat && (owner == PID_W'(g));
        assign wr_ack[g] = wr_beat && (owner == PID_W'(g));
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_sel)) else $error("rd_sel not one-hot"); // R10
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_ack)) else $error("wr_ack not one-hot"); // R10
    AST_NO_MIX: assert property (@(posedge clk) disable iff (rst)
        !((|rd_sel) && (|wr_ack))) else $error("select and ack together"); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        idle |-> (rd_sel == '0) && (wr_ack == '0)) else $error("strobe while idle"); // R10

endmodule

// File: rtl/axi_req_bridge.sv
module axi_req_bridge
    import axib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PID_W-1:0]  req_port,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [LEN_W-1:0]  req_len,
    output logic              done,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    output logic [LEN_W-1:0]  arlen,
    output logic [2:0]        arsize,
    output logic [1:0]        arburst,
    input  logic              rvalid,
    output logic              rready,
    input  logic [DATA_W-1:0] rdata,
    input  logic              rlast,
    output logic              awvalid,
    input  logic              awready,
    output logic [ADDR_W-1:0] awaddr,
    output logic [LEN_W-1:0]  awlen,
    output logic [2:0]        awsize,
    output logic [1:0]        awburst,
    output logic              wvalid,
    input  logic              wready,
    output logic [DATA_W-1:0] wdata,
    output logic              wlast,
    input  logic              bvalid,
    output logic              bready,
    output logic [PORT_N-1:0] rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [PORT_N-1:0] wr_ack,
    input  logic [DATA_W-1:0] wr_data
);

    job_t job_in;
    job_t job;

    always_comb begin
        job_in.port = req_port;
        job_in.addr = req_addr;
        job_in.wr   = req_write;
        job_in.len  = req_len;
    end

    axib_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .job_in    (job_in),
        .req_ready (req_ready),
        .job       (job),
        .done      (done),
        .arvalid   (arvalid),
        .arready   (arready),
        .awvalid   (awvalid),
        .awready   (awready),
        .rvalid    (rvalid),
        .rlast     (rlast),
        .rready    (rready),
        .wvalid    (wvalid),
        .wready    (wready),
        .wlast     (wlast),
        .bvalid    (bvalid),
        .bready    (bready)
    );

    axib_route route_i (
        .clk     (clk),
        .rst     (rst),
        .idle    (req_ready),
        .owner   (job.port),
        .rd_beat (rvalid && rready),
        .wr_beat (wvalid && wready),
        .rd_sel  (rd_sel),
        .wr_ack  (wr_ack)
    );

    assign araddr  = job.addr;
    assign awaddr  = job.addr;
    assign arlen   = final_beat(job.len);
    assign awlen   = final_beat(job.len);
    assign arsize  = BEAT_SIZE;
    assign awsize  = BEAT_SIZE;
    assign arburst = BURST_INCR;
    assign awburst = BURST_INCR;
    assign wdata   = wr_data;
    assign rd_data = rdata;

    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready) else $error("done while busy"); // R11
    AST_AR_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        arvalid && !arready |=> $stable(araddr) && $stable(arlen)) else $error("read address moved"); // R3

endmodule

// File: tb/axi_req_bridge_tb.sv
module axi_req_bridge_tb_top;
    import axib_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_ready;
    logic [PID_W-1:0]  req_port;
    logic [ADDR_W-1:0] req_addr;
    logic              req_write;
    logic [LEN_W-1:0]  req_len;
    logic              done;
    logic              arvalid, arready;
    logic [ADDR_W-1:0] araddr;
    logic [LEN_W-1:0]  arlen;
    logic [2:0]        arsize;
    logic [1:0]        arburst;
    logic              rvalid, rready, rlast;
    logic [DATA_W-1:0] rdata;
    logic              awvalid, awready;
    logic [ADDR_W-1:0] awaddr;
    logic [LEN_W-1:0]  awlen;
    logic [2:0]        awsize;
    logic [1:0]        awburst;
    logic              wvalid, wready, wlast;
    logic [DATA_W-1:0] wdata;
    logic              bvalid, bready;
    logic [PORT_N-1:0] rd_sel;
    logic [DATA_W-1:0] rd_data;
    logic [PORT_N-1:0] wr_ack;
    logic [DATA_W-1:0] wr_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    axi_req_bridge dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_port(req_port), .req_addr(req_addr), .req_write(req_write), .req_len(req_len),
        .done(done), .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
        .arsize(arsize), .arburst(arburst), .rvalid(rvalid), .rready(rready), .rdata(rdata),
        .rlast(rlast), .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
        .awsize(awsize), .awburst(awburst), .wvalid(wvalid), .wready(wready), .wdata(wdata),
        .wlast(wlast), .bvalid(bvalid), .bready(bready), .rd_sel(rd_sel), .rd_data(rd_data),
        .wr_ack(wr_ack), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [DATA_W-1:0] pat(input int s, input int i);
        return {8{s[15:0], i[15:0]}};
    endfunction

    function automatic logic [PORT_N-1:0] bitof(input int p);
        return PORT_N'(1) << p;
    endfunction

    task automatic offer(input int p, input logic [ADDR_W-1:0] a, input bit w, input int n);
        req_port  = PID_W'(p);
        req_addr  = a;
        req_write = w;
        req_len   = LEN_W'(n);
        req_valid = 1'b1;
    endtask

    task automatic accept(input int p, input logic [ADDR_W-1:0] a, input bit w, input int n);
        offer(p, a, w, n);
        step();
        req_valid = 1'b0;
    endtask

    // Runs from the cycle after acceptance. With chain set, a write request is offered with the last beat.
    task automatic read_body(input int p, input logic [ADDR_W-1:0] a, input int n, input int stall,
                             input bit gaps, input bit chain, input int cp, input logic [ADDR_W-1:0] ca, input int cn);
        #1;
        check(arvalid && araddr == a, "R3 araddr", 64'(araddr), 64'(a));
        check(arlen == LEN_W'(n - 1), (n == 1) ? "R12 arlen single" : "R3 arlen", 64'(arlen), 64'(n - 1));
        check(arsize == 3'b101 && arburst == 2'b01, "R3 size/burst", {arsize, arburst}, {3'b101, 2'b01});
        for (int k = 0; k < stall; k++) begin
            step();
            check(arvalid && araddr == a, "R3 held under stall", 64'(arvalid), 64'd1);
        end
        arready = 1'b1;
        step();
        arready = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 2 == 1)) begin
                rvalid = 1'b0;
                #1;
                check(rready && rd_sel == '0, "R5 no select in gap", 64'(rd_sel), 64'd0);
                step();
            end
            rvalid = 1'b1;
            rdata  = pat(p + 16, i);
            rlast  = (i == n - 1);
            if (chain && i == n - 1) offer(cp, ca, 1'b1, cn);
            #1;
            check(rready && rd_sel == bitof(p), "R5 rd_sel", 64'(rd_sel), 64'(bitof(p)));
            check(rd_data == pat(p + 16, i), "R5 rd_data", rd_data[63:0], pat(p + 16, i) & 64'hFFFF_FFFF_FFFF_FFFF);
            step();
        end
        rvalid = 1'b0;
        rlast  = 1'b0;
        #1;
        check(done && req_ready, chain ? "R11 done with ready" : "R9 read done", {done, req_ready}, 2'b11);
        check(rd_sel == '0, "R10 idle select", 64'(rd_sel), 64'd0);
        if (!chain) begin
            step();
            check(!done, "R9 done one cycle", 64'(done), 64'd0);
        end
    endtask

    task automatic write_body(input int p, input logic [ADDR_W-1:0] a, input int n, input int stall, input bit wgaps);
        #1;
        check(awvalid && awaddr == a, "R4 awaddr", 64'(awaddr), 64'(a));
        check(awlen == LEN_W'(n - 1), (n == 1) ? "R12 awlen single" : "R4 awlen", 64'(awlen), 64'(n - 1));
        check(awsize == 3'b101 && awburst == 2'b01, "R4 size/burst", {awsize, awburst}, {3'b101, 2'b01});
        for (int k = 0; k < stall; k++) begin
            step();
            check(awvalid && awaddr == a, "R4 held under stall", 64'(awvalid), 64'd1);
        end
        awready = 1'b1;
        step();
        awready = 1'b0;
        for (int i = 0; i < n; i++) begin
            wr_data = pat(p + 32, i);
            if (wgaps) begin
                wready = 1'b0;
                #1;
                check(wvalid && wr_ack == '0, "R6 no ack while stalled", 64'(wr_ack), 64'd0);
                step();
            end
            wready = 1'b1;
            #1;
            check(wvalid && wdata == pat(p + 32, i), "R6 wdata", wdata[63:0], pat(p + 32, i) & 64'hFFFF_FFFF_FFFF_FFFF);
            check(wr_ack == bitof(p), "R6 wr_ack", 64'(wr_ack), 64'(bitof(p)));
            check(wlast == (i == n - 1), (n == 1) ? "R12 wlast single" : "R7 wlast", 64'(wlast), 64'(i == n - 1));
            step();
        end
        wready = 1'b0;
        #1;
        check(bready && !wvalid && !done, "R8 wait response", {bready, wvalid, done}, 3'b100);
        step();
        check(bready && !done, "R8 still waiting", {bready, done}, 2'b10);
        bvalid = 1'b1;
        step();
        bvalid = 1'b0;
        #1;
        check(done && req_ready && wr_ack == '0, "R8 write done", {done, req_ready}, 2'b11);
        step();
        check(!done, "R8 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        req_valid = 0; req_port = '0; req_addr = '0; req_write = 0; req_len = '0;
        arready = 0; rvalid = 0; rdata = '0; rlast = 0; awready = 0; wready = 0; bvalid = 0; wr_data = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        check(req_ready && !done, "R1 ready after reset", {req_ready, done}, 2'b10);
        check(!(arvalid || awvalid || wvalid || rready || bready), "R1 channels quiet",
              {arvalid, awvalid, wvalid, rready, bready}, 5'b0);
        check(rd_sel == '0 && wr_ack == '0, "R1 strobes zero", {rd_sel, wr_ack}, 0);
    endtask

    task automatic t_read_basic();
        accept(2, 32'h1000_0040, 1'b0, 4);
        read_body(2, 32'h1000_0040, 4, 2, 1'b1, 1'b0, 0, '0, 0);
    endtask

    task automatic t_read_single();
        accept(0, 32'h0000_2000, 1'b0, 1);
        read_body(0, 32'h0000_2000, 1, 0, 1'b0, 1'b0, 0, '0, 0);
    endtask

    task automatic t_write_basic();
        accept(3, 32'hABCD_0100, 1'b1, 5);
        write_body(3, 32'hABCD_0100, 5, 1, 1'b1);
    endtask

    task automatic t_write_single();
        accept(1, 32'h0000_0A00, 1'b1, 1);
        write_body(1, 32'h0000_0A00, 1, 0, 1'b0);
    endtask

    task automatic t_ignore_busy();
        accept(1, 32'h0000_3000, 1'b0, 2);
        offer(3, 32'hDEAD_0000, 1'b1, 3);
        #1;
        check(!req_ready, "R2 busy not ready", 64'(req_ready), 64'd0);
        step();
        req_valid = 1'b0;
        read_body(1, 32'h0000_3000, 2, 0, 1'b0, 1'b0, 0, '0, 0);
        for (int k = 0; k < 3; k++) begin
            check(!arvalid && !awvalid && req_ready, "R2 busy request dropped", {arvalid, awvalid}, 2'b00);
            step();
        end
    endtask

    task automatic t_chain();
        accept(2, 32'h0000_4000, 1'b0, 2);
        read_body(2, 32'h0000_4000, 2, 0, 1'b0, 1'b1, 0, 32'h0000_5000, 3);
        step();
        req_valid = 1'b0;
        check(awvalid && awaddr == 32'h0000_5000, "R11 next address phase", 64'(awaddr), 64'h5000);
        write_body(0, 32'h0000_5000, 3, 0, 1'b0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1-chain hung actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_read_basic();
        t_read_single();
        t_write_basic();
        t_write_single();
        t_ignore_busy();
        t_chain();
        summary();
        $finish;
    end

endmodule